// File: doc/BRIEF.md
# Read Port Randomizer for Undefined Memory Reads

This block sits between a memory array's read port and whatever consumes the read data. Its job is to stand in for any read whose result is not defined, so that a model or design cannot quietly rely on such a value. In those cases it returns a word from its own pseudo-random source in place of the array's data. There are three undefined cases:

- the port is disabled;
- the index lies past the last valid entry, which can only happen when the depth is not a power of two;
- on a registered (latency-one) port, the read targets the same entry as a write in the same cycle.

All three cases are merged into one randomize decision. On a registered port that decision is delayed by one cycle so that it lines up with the data the array returns. The same decision also advances the random source, so the source moves on only when one of its words is actually handed out. A check mode can be enabled to raise an alarm output in any cycle where an enabled read carries an out-of-range index. The array itself and its write logic belong to the surrounding design.

Top module: `rdport_randomizer`

## Requirements
- R1: When `rdEn` is 0, the read is undefined and `rdData` equals the current random word at the output stage of the port.
- R2: When `rdEn` is 1 and `rdAddr` is greater than or equal to `DEPTH`, the read is undefined. With `DEPTH`=30, indices 30 and 31 are randomized.
- R3: An enabled, in-range read with no collision returns `memData` unchanged.
- R4: When `DEPTH` equals 2**`ADDR_W`, no index is treated as out of range, and every enabled read returns `memData`.
- R5: With `LATENCY`=1, the randomize decision formed from the inputs at a clock edge selects `rdData` during the following cycle. With `LATENCY`=0, the decision selects `rdData` in the same cycle as the inputs.
- R6: With `LATENCY`=1 and `COLLIDE_CHK`=1, a cycle with `rdEn`=1, `wrEn`=1 and `rdAddr`==`wrAddr` randomizes the next cycle's `rdData`. With `LATENCY`=0, a collision has no effect.
- R7: The random word is a Galois LFSR of width `DATA_W`. Each step is `next = (s >> 1) ^ (s[0] ? TAPS : 0)`, with `TAPS`=32'h80200003 by default. The LFSR steps at a clock edge only when the output-stage randomize decision is 1; otherwise it holds.
- R8: With `CHECK_OOB`=1, `oobAlarm` is 1 in exactly the cycles where `rdEn` is 1 and `rdAddr` >= `DEPTH`.
- R9: While `rstN` is 0, the LFSR is loaded with `SEED` (nonzero, default 32'hACE1_2461) and the registered decision clears. The first random word handed out after reset is therefore `SEED`, and a latency-one port passes `memData` during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read enable |
| rdAddr | input | ADDR_W | Read index |
| wrEn | input | 1 | Enable of the write port sharing the array |
| wrAddr | input | ADDR_W | Index of that write port |
| memData | input | DATA_W | Data returned by the array, already aligned to the read latency |
| rdData | output | DATA_W | Read data after undefined reads are randomized |
| oobAlarm | output | 1 | Out-of-range enabled read, valid when `CHECK_OOB` is 1 |

## Verification
The assertions assume that `memData` is already aligned to the configured latency by the surrounding array. They also assume that reset is held for at least one clock edge, so the registered decision and the LFSR start from known values. The stimulus keeps to this: reset is held for several edges, and `memData` is driven as a free value in every cycle, so the output is always either that word or the modelled LFSR word. Random indices cover the whole `ADDR_W` range, which includes the out-of-range entries. The write index is biased toward the read index so that collisions occur often.

// File: rtl/rdrand_pkg.sv
package rdrand_pkg;
  // Strobes from the decision logic to the data path.
  typedef struct packed {
    logic doRand;   // select the random word at the output
    logic advance;  // step the random source at the next edge
  } rnd_strobe_t;
endpackage

// File: rtl/rdport_rand_ctrl.sv
module rdport_rand_ctrl
  import rdrand_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DEPTH       = 30,
  parameter int LATENCY     = 1,
  parameter bit COLLIDE_CHK = 1'b1,
  parameter bit CHECK_OOB   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output rnd_strobe_t       strb,
  output logic              oobAlarm
);
  localparam int FULL_SPAN = 1 << ADDR_W;
  localparam bit FULL_RANGE = (DEPTH >= FULL_SPAN);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);
  localparam bit COLLIDE_EN = (LATENCY == 1) && COLLIDE_CHK;

  logic oobRaw;
  logic collide;
  logic decideNow;
  logic decideOut;
  logic primed;

  // The range term only exists when the depth leaves unused indices.
  generate
    if (FULL_RANGE) begin : g_noRange
      assign oobRaw = 1'b0;
    end else begin : g_range
      assign oobRaw = rdEn && ({1'b0, rdAddr} >= DEPTH_V);
    end
  endgenerate

  assign collide   = COLLIDE_EN && rdEn && wrEn && (rdAddr == wrAddr);
  assign decideNow = !rdEn || oobRaw || collide;

  generate
    if (LATENCY == 0) begin : g_lat0
      assign decideOut = decideNow;
    end else begin : g_lat1
      logic decideQ;
      always_ff @(posedge clk) begin
        if (!rstN) decideQ <= 1'b0;
        else       decideQ <= decideNow;
      end
      assign decideOut = decideQ;
    end
  endgenerate

  // Set once an edge has passed since reset, so that $past is meaningful.
  always_ff @(posedge clk) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  assign strb.doRand  = decideOut;
  assign strb.advance = decideOut;
  assign oobAlarm     = CHECK_OOB && oobRaw;

  // R8: the alarm is only raised for an enabled read.
  p_alarm_enabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    oobAlarm |-> rdEn);

  generate
    if (LATENCY == 0) begin : g_chk0
      // R1: a disabled read is randomized in the same cycle.
      p_disabled_r1: assert property (@(posedge clk) disable iff (!rstN)
        !rdEn |-> strb.doRand);
      // R2: an alarmed read is randomized in the same cycle.
      p_oob_rand_r2: assert property (@(posedge clk) disable iff (!rstN)
        oobAlarm |-> strb.doRand);
    end else begin : g_chk1
      // R5: a disabled read selects random data one cycle later.
      p_disabled_late_r5: assert property (@(posedge clk) disable iff (!rstN)
        (primed && $past(!rdEn)) |-> strb.doRand);
      if (COLLIDE_EN) begin : g_chkCol
        // R6: a same-index collision randomizes the following cycle.
        p_collide_r6: assert property (@(posedge clk) disable iff (!rstN)
          (primed && $past(rdEn && wrEn && (rdAddr == wrAddr))) |-> strb.doRand);
      end
    end
  endgenerate
endmodule

// File: rtl/rdport_rand_dp.sv
module rdport_rand_dp
  import rdrand_pkg::*;
#(
  parameter int               DATA_W = 32,
  parameter logic [DATA_W-1:0] TAPS  = 32'h8020_0003,
  parameter logic [DATA_W-1:0] SEED  = 32'hACE1_2461
) (
  input  logic              clk,
  input  logic              rstN,
  input  rnd_strobe_t       strb,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] lfsrQ;
  logic [DATA_W-1:0] lfsrNext;

  assign lfsrNext = (lfsrQ >> 1) ^ (lfsrQ[0] ? TAPS : '0);

  always_ff @(posedge clk) begin
    if (!rstN)             lfsrQ <= SEED;
    else if (strb.advance) lfsrQ <= lfsrNext;
  end

  assign rdData = strb.doRand ? lfsrQ : memData;

  // R7: the source holds in every cycle that hands out no random word.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(lfsrQ));
  // R7: the source never reaches the all-zero lockup state.
  p_nonzero_r7: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);
  // R7: each step moves the state.
  p_moves_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (lfsrQ != $past(lfsrQ)));
endmodule

// File: rtl/rdport_randomizer.sv
module rdport_randomizer
  import rdrand_pkg::*;
#(
  parameter int                ADDR_W      = 5,
  parameter int                DEPTH       = 30,
  parameter int                DATA_W      = 32,
  parameter int                LATENCY     = 1,
  parameter bit                COLLIDE_CHK = 1'b1,
  parameter bit                CHECK_OOB   = 1'b1,
  parameter logic [DATA_W-1:0] TAPS        = 32'h8020_0003,
  parameter logic [DATA_W-1:0] SEED        = 32'hACE1_2461
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] rdData,
  output logic              oobAlarm
);
  rnd_strobe_t strb;

  rdport_rand_ctrl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .LATENCY(LATENCY),
    .COLLIDE_CHK(COLLIDE_CHK), .CHECK_OOB(CHECK_OOB)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .strb(strb), .oobAlarm(oobAlarm)
  );

  rdport_rand_dp #(
    .DATA_W(DATA_W), .TAPS(TAPS), .SEED(SEED)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memData(memData), .rdData(rdData)
  );
endmodule

// File: tb/rdport_randomizer_bench.sv
module rdport_randomizer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam logic [31:0] SEED = 32'hACE1_2461;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b1;
  logic [4:0]  rdAddr = 5'd3;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = 5'd0;
  logic [31:0] memData = 32'hA5A5_0001;
  logic [31:0] outL1, outL0, outPw;
  logic        almL1, almL0, almPw;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] modL1, modL0, modPw;
  bit pendL1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdport_randomizer #(.DEPTH(30), .LATENCY(1)) u_rdport_randomizer (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn),
    .wrAddr(wrAddr), .memData(memData), .rdData(outL1), .oobAlarm(almL1));

  rdport_randomizer #(.DEPTH(30), .LATENCY(0)) u_rdport_randomizer_l0 (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn),
    .wrAddr(wrAddr), .memData(memData), .rdData(outL0), .oobAlarm(almL0));

  rdport_randomizer #(.DEPTH(32), .LATENCY(0)) u_rdport_randomizer_pw (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn),
    .wrAddr(wrAddr), .memData(memData), .rdData(outPw), .oobAlarm(almPw));

  function automatic logic [31:0] lfsrStep(logic [31:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : 32'h0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check 1 time unit later, then
  // let the rising edge pass and update the models.
  task automatic step(bit en, logic [4:0] a, bit we, logic [4:0] wa,
                      logic [31:0] md, string tagL0 = "");
    bit fL0, fPw, oob, col;
    string t;
    @(negedge clk);
    rdEn = en; rdAddr = a; wrEn = we; wrAddr = wa; memData = md;
    #1;
    oob = en && (a >= 5'd30);
    col = en && we && (a == wa);
    fL0 = !en || oob;
    fPw = !en;
    t = (tagL0 != "") ? tagL0 : (!en ? "R1" : (oob ? "R2" : "R3"));
    check(t, outL0, fL0 ? modL0 : md);
    check(pendL1 ? "R6 R5" : "R5", outL1, pendL1 ? modL1 : md);
    check(en ? "R4" : "R7", outPw, fPw ? modPw : md);
    check("R8", {31'b0, almL0}, {31'b0, oob});
    check("R8 R4", {31'b0, almPw}, 32'h0);
    @(posedge clk);
    if (fL0) modL0 = lfsrStep(modL0);
    if (fPw) modPw = lfsrStep(modPw);
    if (pendL1) modL1 = lfsrStep(modL1);
    pendL1 = !en || oob || col;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R9: during reset the latency-one port passes memData through.
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R9", outL1, memData);
    check("R9", outPw, memData);
    rstN = 1'b1;
    modL1 = SEED; modL0 = SEED; modPw = SEED; pendL1 = 1'b0;

    // R9: the first random word is the seed.
    step(1'b0, 5'd4, 1'b0, 5'd0, 32'h1111_0000, "R9");
    step(1'b0, 5'd4, 1'b0, 5'd0, 32'h1111_0001, "R1");
    // R2: indices 30 and 31 are out of range; R3: 29 and 0 are in range.
    step(1'b1, 5'd30, 1'b0, 5'd0, 32'h2222_0000);
    step(1'b1, 5'd31, 1'b0, 5'd0, 32'h2222_0001);
    step(1'b1, 5'd29, 1'b0, 5'd0, 32'h3333_0000);
    step(1'b1, 5'd0, 1'b0, 5'd0, 32'h3333_0001);
    // R6: a collision randomizes the next cycle at latency one only.
    step(1'b1, 5'd7, 1'b1, 5'd7, 32'h6666_0000);
    step(1'b1, 5'd8, 1'b1, 5'd9, 32'h6666_0001);
    step(1'b1, 5'd8, 1'b0, 5'd8, 32'h6666_0002);
    step(1'b1, 5'd2, 1'b0, 5'd2, 32'h6666_0003);
    // R7: a long run of in-range reads leaves the source unchanged.
    for (int i = 0; i < 5; i++) step(1'b1, 5'(i), 1'b0, 5'd0, 32'h7777_0000 + i);
    step(1'b0, 5'd1, 1'b0, 5'd0, 32'h7777_1000, "R7");

    for (int i = 0; i < 2000; i++) begin
      bit en;
      bit we;
      logic [4:0] a;
      logic [4:0] wa;
      en = ($urandom % 10) < 7;
      we = $urandom % 2;
      a  = 5'($urandom);
      wa = (($urandom % 3) == 0) ? a : 5'($urandom);
      step(en, a, we, wa, $urandom);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule